// File: doc/BRIEF.md
# Triggered Acquisition Timing Sequencer

This block paces a two-channel sampling run. Software programs two control values: how many points a scan takes, and the sample-period divisor in system clock cycles. A scan starts on either a one-cycle software trigger or a falling edge on an external active-low trigger line. During the scan the block issues one sample strobe per programmed period. A point index tells downstream logic which point the current strobe belongs to. After the last strobe, a one-cycle scan-done pulse ends the run, and the block is idle again, ready for the next trigger.

A separate active-low stop line has priority over everything else. Holding it low aborts a running scan without a done pulse, and it keeps the sequencer idle for as long as it stays low. Both external lines pass through two-flop synchronizers. Both control values are copied at scan start, so software may reprogram them at any time without disturbing a scan in flight. With a 50 MHz clock, the default 20-bit divisor covers sample rates from 100 kHz down to below 60 Hz.

Top module: `acq_sequencer`

## Requirements
- R1: After reset the points register reads `RST_POINTS` and the divisor register reads `RST_PERIOD`. `sample_stb`, `scan_done` and `busy` are low, and `point_idx` is 0.
- R2: A write with `reg_wr` high stores `reg_wdata` into the register chosen by `reg_addr` (0 = points, truncated to `COUNT_W` bits; 1 = divisor, truncated to `PERIOD_W` bits). The write takes effect at that clock edge. `reg_rdata` shows the register chosen by `reg_addr`, zero-extended.
- R3: If `sw_trig` is high at a clock edge while the block is idle, a scan of N points with divisor D starts at that edge. The j-th strobe (j = 1..N) is high during the cycle that begins j·D−1 edges after the start edge. `sample_stb` implies `busy`.
- R4: A divisor of 0 behaves as a divisor of 1, which gives one strobe every cycle.
- R5: `point_idx` is 0 from the start edge onward and increments after each strobe. During a strobe it equals that strobe's zero-based index, and it holds N after the scan.
- R6: `scan_done` is high for exactly the one cycle that follows the last strobe, with `busy` still high, and `busy` is low in the cycle after that. With N = 0 there is no strobe, and `scan_done` is high in the first cycle after the start edge.
- R7: A falling edge on `ext_trig_n` that is set up before clock edge e starts a scan at edge e+2. Holding the line low starts only one scan, and a new scan needs a fresh high-to-low transition.
- R8: Software or external triggers that arrive while `busy` is high are ignored. They neither restart the current scan nor queue a new one.
- R9: A register write during a scan does not change that scan. The next scan uses the new values.
- R10: `stop_n` low, set up before edge e, aborts a scan at edge e+2. `busy` drops, `point_idx` returns to 0 and no `scan_done` follows. While `stop_n` stays low, triggers are ignored. The registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 points, 1 divisor |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for selected register |
| sw_trig | input | 1 | Software trigger, one-cycle pulse |
| ext_trig_n | input | 1 | External trigger, active low, asynchronous |
| stop_n | input | 1 | Stop/abort line, active low, asynchronous |
| sample_stb | output | 1 | One-cycle sample strobe |
| point_idx | output | COUNT_W | Index of the current/next point |
| scan_done | output | 1 | One-cycle end-of-scan pulse |
| busy | output | 1 | Scan in progress |

## Verification
The bench builds the block with `COUNT_W` = 4 and `PERIOD_W` = 5. Small values like these let it sweep every divisor from 0 to 5 against every point count from 0 to 4, comparing strobe, index, done and busy cycle by cycle against an arithmetic model. The narrow registers make the truncation of over-wide writes visible. The short scans leave room for the timing-exact tests of external-trigger latency, one-scan-per-edge, abort, and writes or triggers landing mid-scan.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } acq_state_t;

  localparam logic ADDR_POINTS = 1'b0;
  localparam logic ADDR_PERIOD = 1'b1;
endpackage

// File: rtl/acq_regs.sv
module acq_regs #(
  parameter int COUNT_W    = 18,
  parameter int PERIOD_W   = 20,
  parameter int RST_POINTS = 256,
  parameter int RST_PERIOD = 500
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic                addr,
  input  logic [31:0]         wdata,
  output logic [31:0]         rdata,
  output logic [COUNT_W-1:0]  points,
  output logic [PERIOD_W-1:0] period
);
  import acq_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      points <= COUNT_W'(RST_POINTS);
      period <= PERIOD_W'(RST_PERIOD);
    end else if (wr) begin
      if (addr == ADDR_POINTS) points <= wdata[COUNT_W-1:0];
      else                     period <= wdata[PERIOD_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_POINTS) rdata[COUNT_W-1:0]  = points;
    else                     rdata[PERIOD_W-1:0] = period;
  end
endmodule

// File: rtl/acq_sync_edge.sv
module acq_sync_edge #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {STAGES{RST_VAL}};
      prev  <= RST_VAL;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prev  <= chain[STAGES-1];
    end
  end

  assign dout = chain[STAGES-1];
  assign fall = prev & ~chain[STAGES-1];
endmodule

// File: rtl/acq_pacer.sv
module acq_pacer #(
  parameter int PERIOD_W = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                run,
  input  logic [PERIOD_W-1:0] period,
  output logic                tick
);
  logic [PERIOD_W-1:0] cnt;
  logic [PERIOD_W-1:0] reload_q;

  function automatic logic [PERIOD_W-1:0] reload_of(input logic [PERIOD_W-1:0] d);
    return (d == '0) ? '0 : d - 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      reload_q <= '0;
    end else if (load) begin
      cnt      <= reload_of(period);
      reload_q <= reload_of(period);
    end else if (run) begin
      if (cnt == '0) cnt <= reload_q;
      else           cnt <= cnt - 1'b1;
    end
  end

  assign tick = run && (cnt == '0);
endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer #(
  parameter int COUNT_W    = 18,
  parameter int PERIOD_W   = 20,
  parameter int RST_POINTS = 256,
  parameter int RST_PERIOD = 500
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic               sw_trig,
  input  logic               ext_trig_n,
  input  logic               stop_n,
  output logic               sample_stb,
  output logic [COUNT_W-1:0] point_idx,
  output logic               scan_done,
  output logic               busy
);
  import acq_pkg::*;

  acq_state_t          state;
  logic [COUNT_W-1:0]  points;
  logic [PERIOD_W-1:0] period;
  logic [COUNT_W-1:0]  n_lat;
  logic                ext_sync, ext_fall;
  logic                stop_sync, stop_fall;
  logic                stop_act, start_req, start_evt, abort_evt, last_evt, tick;

  acq_regs #(
    .COUNT_W(COUNT_W), .PERIOD_W(PERIOD_W),
    .RST_POINTS(RST_POINTS), .RST_PERIOD(RST_PERIOD)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .points(points), .period(period)
  );

  acq_sync_edge #(.STAGES(2), .RST_VAL(1'b1)) u_trig_sync (
    .clk(clk), .rst_n(rst_n), .din(ext_trig_n), .dout(ext_sync), .fall(ext_fall)
  );

  acq_sync_edge #(.STAGES(2), .RST_VAL(1'b1)) u_stop_sync (
    .clk(clk), .rst_n(rst_n), .din(stop_n), .dout(stop_sync), .fall(stop_fall)
  );

  acq_pacer #(.PERIOD_W(PERIOD_W)) u_pacer (
    .clk(clk), .rst_n(rst_n), .load(start_evt),
    .run(state == ST_RUN), .period(period), .tick(tick)
  );

  // named events for the checker
  assign stop_act  = ~stop_sync;
  assign start_req = sw_trig | ext_fall;
  assign start_evt = (state == ST_IDLE) && start_req && !stop_act;
  assign abort_evt = stop_act && (state != ST_IDLE);
  assign last_evt  = tick && (point_idx == n_lat - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      point_idx <= '0;
      n_lat     <= '0;
    end else if (stop_act) begin
      state     <= ST_IDLE;
      point_idx <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start_evt) begin
          point_idx <= '0;
          n_lat     <= points;
          state     <= (points == '0) ? ST_DONE : ST_RUN;
        end
        ST_RUN: if (tick) begin
          point_idx <= point_idx + 1'b1;
          if (last_evt) state <= ST_DONE;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sample_stb = tick;
  assign scan_done  = (state == ST_DONE);
  assign busy       = (state != ST_IDLE);
endmodule

// File: rtl/acq_sequencer_chk.sv
module acq_sequencer_chk #(
  parameter int CW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sample_stb,
  input logic          scan_done,
  input logic          busy,
  input logic [CW-1:0] point_idx,
  input logic          start_evt,
  input logic          abort_evt
);
  // R3
  stb_in_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> busy);

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> (!scan_done && !busy));

  // R5
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && !abort_evt) |=> (point_idx == $past(point_idx) + 1'b1));

  // R5
  idx_zero_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (busy && point_idx == '0));

  // R10
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (!busy && !scan_done && point_idx == '0));
endmodule

bind acq_sequencer acq_sequencer_chk #(.CW(COUNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .scan_done(scan_done),
  .busy(busy), .point_idx(point_idx), .start_evt(start_evt), .abort_evt(abort_evt)
);

// File: tb/acq_sequencer_test.sv
module acq_sequencer_test;
  localparam int CW = 4;
  localparam int PW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic          reg_addr = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          sw_trig = 1'b0;
  logic          ext_trig_n = 1'b1;
  logic          stop_n = 1'b1;
  logic          sample_stb, scan_done, busy;
  logic [CW-1:0] point_idx;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  acq_sequencer #(.COUNT_W(CW), .PERIOD_W(PW), .RST_POINTS(3), .RST_PERIOD(7)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sw_trig(sw_trig),
    .ext_trig_n(ext_trig_n), .stop_n(stop_n), .sample_stb(sample_stb),
    .point_idx(point_idx), .scan_done(scan_done), .busy(busy)
  );

  task automatic check(input string tag, input longint got, input longint exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr_reg(input logic a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_check(input string tag, input logic a, input longint exp);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, exp);
  endtask

  // pulse sw_trig across one edge; returns at negedge of cycle c=0
  task automatic kick_sw;
    @(negedge clk);
    sw_trig = 1'b1;
    @(negedge clk);
    sw_trig = 1'b0;
  endtask

  // cycle-by-cycle model: strobe j at c=j*D-1, done at c=N*D
  task automatic scan_check(input string tag, input int n, input int d);
    int de;
    de = (d == 0) ? 1 : d;
    for (int c = 0; c <= n * de + 1; c++) begin
      int idx;
      idx = c / de;
      if (idx > n) idx = n;
      check({tag, " stb"},  sample_stb, ((c + 1) % de == 0) && (c + 1 <= n * de));
      check({tag, " idx"},  point_idx, idx);
      check({tag, " done"}, scan_done, c == n * de);
      check({tag, " busy"}, busy, c <= n * de);
      @(negedge clk);
    end
  endtask

  task automatic quiet_check(input string tag, input int cycles);
    for (int k = 0; k < cycles; k++) begin
      check({tag, " stb"},  sample_stb, 0);
      check({tag, " done"}, scan_done, 0);
      check({tag, " busy"}, busy, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    #1600000;
    n_fail++;
    $display("FAIL watchdog: got hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd_check("R1 points", 1'b0, 3);
    rd_check("R1 period", 1'b1, 7);
    check("R1 stb", sample_stb, 0);
    check("R1 done", scan_done, 0);
    check("R1 busy", busy, 0);
    check("R1 idx", point_idx, 0);

    // R2 write/readback with truncation
    wr_reg(1'b0, 32'hFFFF_FFF9);
    wr_reg(1'b1, 32'hABCD_EF35);
    rd_check("R2 points", 1'b0, 9);
    rd_check("R2 period", 1'b1, 21);

    // R3 R4 R5 R6 sweep of divisor and count
    for (int d = 0; d <= 5; d++) begin
      for (int n = 0; n <= 4; n++) begin
        wr_reg(1'b0, n);
        wr_reg(1'b1, d);
        kick_sw();
        scan_check((d == 0) ? "R4 sweep" : ((n == 0) ? "R6 sweep" : "R3 sweep"), n, d);
      end
    end

    // R7 external trigger: start at e+2, one scan per edge
    wr_reg(1'b0, 2);
    wr_reg(1'b1, 2);
    @(negedge clk);
    ext_trig_n = 1'b0;
    repeat (3) @(negedge clk);
    scan_check("R7 ext", 2, 2);
    quiet_check("R7 held", 10);
    ext_trig_n = 1'b1;
    repeat (4) @(negedge clk);
    ext_trig_n = 1'b0;
    repeat (3) @(negedge clk);
    scan_check("R7 reedge", 2, 2);
    ext_trig_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8 triggers during a scan are ignored; R9 writes apply next scan
    wr_reg(1'b0, 3);
    wr_reg(1'b1, 3);
    kick_sw();
    fork
      scan_check("R8 busy", 3, 3);
      begin
        sw_trig = 1'b1;
        @(negedge clk);
        sw_trig = 1'b0;
        ext_trig_n = 1'b0;
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 32'd2;
        @(negedge clk);
        reg_addr = 1'b1; reg_wdata = 32'd4;
        @(negedge clk);
        reg_wr = 1'b0;
        ext_trig_n = 1'b1;
        repeat (2) @(negedge clk);
        sw_trig = 1'b1;
        @(negedge clk);
        sw_trig = 1'b0;
      end
    join
    quiet_check("R8 noqueue", 6);
    rd_check("R9 points", 1'b0, 2);
    rd_check("R9 period", 1'b1, 4);
    kick_sw();
    scan_check("R9 next", 2, 4);

    // R10 stop aborts, blocks triggers, keeps registers
    wr_reg(1'b0, 4);
    wr_reg(1'b1, 3);
    kick_sw();
    repeat (4) @(negedge clk);
    check("R10 prebusy", busy, 1);
    stop_n = 1'b0;
    @(negedge clk);
    check("R10 still1", busy, 1);
    @(negedge clk);
    check("R10 still2", busy, 1);
    @(negedge clk);
    check("R10 aborted", busy, 0);
    check("R10 idx", point_idx, 0);
    quiet_check("R10 after", 12);
    sw_trig = 1'b1;
    @(negedge clk);
    sw_trig = 1'b0;
    quiet_check("R10 blocked", 6);
    rd_check("R10 points", 1'b0, 4);
    rd_check("R10 period", 1'b1, 3);
    stop_n = 1'b1;
    repeat (3) @(negedge clk);
    kick_sw();
    scan_check("R10 resume", 4, 3);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule